// File: doc/BRIEF.md
# Masked-Write GPIO Port Register Bank

This block holds the control state for one port of eight general-purpose pins and sits on a plain memory-mapped bus: one select, one write strobe, a byte address and a 32-bit data word. Three per-pin control registers decide whether the pin belongs to the GPIO function (ownership), whether it is driven (drive-enable), and the level it drives (drive-level). A fourth, read-only register shows the pad inputs once they have passed through a two-flop synchroniser.

Each control register can be written in two ways. A direct write replaces all eight bits. A write to its masked alias changes only the bits named in the upper byte of the data word, so software can flip one pin without reading the register first and without racing another agent that is changing a different pin. The alias of each register sits at its direct offset plus a fixed alias offset, which is a parameter. The block drives the pad output level and the pad drive-enable directly from these registers.

Top module: `gpio_port_regs`

## Requirements
- R1: After reset every control register reads zero, `pad_out` is 0x00 and `pad_oe` is 0x00, so every pin starts as an undriven, unowned input.
- R2: A direct write to byte offset 0x00 (ownership), 0x10 (drive-enable) or 0x20 (drive-level) replaces all eight bits of that register with write-data bits 7:0; write-data bits 31:8 are ignored.
- R3: A write to a masked alias (direct offset plus `ALIAS_OFS`, default 0x80) updates register bit n only when write-data bit 8+n is 1, loading it from write-data bit n; every bit with a zero mask bit keeps its value.
- R4: A read of a masked alias returns the current register value in bits 7:0 and zero in bits 31:8.
- R5: `pad_out` equals the drive-level register, and `pad_oe` bit n is 1 only when both ownership bit n and drive-enable bit n are 1.
- R6: The input register at offset 0x30 shows `pad_in` after two rising clock edges; after only one edge it still shows the previous value.
- R7: A read of offset 0x30 returns, for each pin n, drive-level bit n when drive-enable bit n is 1 and the synchronised input bit n otherwise.
- R8: Writes to offset 0x30, to the alias of 0x30 and to unmapped offsets change no register, and reads of unmapped offsets return zero.
- R9: With `bus_sel` low, a write strobe changes no register.
- R10: A read of a direct control offset returns the register in bits 7:0 and zero in bits 31:8.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Bus access select |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 12 | Byte offset of the access |
| bus_wdata | input | 32 | Write data; bits 15:8 are the mask on an alias write |
| bus_rdata | output | 32 | Read data, valid in the same cycle as the read |
| pad_in | input | 8 | Asynchronous pad input levels |
| pad_out | output | 8 | Pad output levels |
| pad_oe | output | 8 | Pad drive-enables |

## Verification
The hardest situation to reach is a masked write whose mask covers some pins while the unmasked pins hold a mix of ones and zeros, since a wrong merge only shows when a kept bit differs from the written data. The bench first loads each register with an irregular pattern by direct write, then issues alias writes whose masks split that pattern, including an empty mask, and reads back both through the alias and the direct offset. The input-path view is reached by leaving some pins drive-enabled with a drive level opposite to the pad, so each bit of the read shows which source was picked.

// File: rtl/gpio_port_pkg.sv
package gpio_port_pkg;
  // Index of each control register; direct offset is index * CTL_STRIDE
  typedef enum logic [1:0] {
    CTL_OWN   = 2'd0,
    CTL_DRVEN = 2'd1,
    CTL_LEVEL = 2'd2
  } ctl_idx_t;

  localparam int NUM_CTL    = 3;
  localparam int CTL_STRIDE = 16;
  localparam int IN_INDEX   = 3;
endpackage

// File: rtl/gpio_port_sync.sv
module gpio_port_sync #(
  parameter int PIN_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [PIN_W-1:0] async_in,
  output logic [PIN_W-1:0] sync_out
);
  logic [PIN_W-1:0] meta_q;
  logic [PIN_W-1:0] stab_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      stab_q <= '0;
    end else begin
      meta_q <= async_in;
      stab_q <= meta_q;
    end
  end

  assign sync_out = stab_q;

  // edges seen since reset, saturating at 2, for the latency check
  logic [1:0] age_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              age_q <= 2'd0;
    else if (age_q != 2'd2)  age_q <= age_q + 2'd1;
  end

  // R6
  sync_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (age_q == 2'd2) |-> (sync_out == $past(async_in, 2)));
endmodule

// File: rtl/gpio_port_ctlreg.sv
module gpio_port_ctlreg #(
  parameter int PIN_W  = 8,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_full,
  input  logic              wr_masked,
  input  logic [DATA_W-1:0] wdata,
  output logic [PIN_W-1:0]  q
);
  logic [PIN_W-1:0] mask;
  logic [PIN_W-1:0] val;
  logic [PIN_W-1:0] q_nxt;
  logic             q_en;

  assign val  = wdata[PIN_W-1:0];
  assign mask = wdata[2*PIN_W-1:PIN_W];
  assign q_en = wr_full | wr_masked;

  always_comb begin
    q_nxt = q;
    if (wr_full)        q_nxt = val;
    else if (wr_masked) q_nxt = (q & ~mask) | (val & mask);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    q <= '0;
    else if (q_en) q <= q_nxt;
  end

  // R2
  full_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_full |=> (q == $past(wdata[PIN_W-1:0])));
  // R3
  masked_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_masked && !wr_full) |=> (((q ^ $past(q)) & ~$past(wdata[2*PIN_W-1:PIN_W])) == '0));
  // R3
  masked_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_masked && !wr_full) |=> (((q ^ $past(wdata[PIN_W-1:0])) & $past(wdata[2*PIN_W-1:PIN_W])) == '0));
  // R9
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_full && !wr_masked) |=> $stable(q));
endmodule

// File: rtl/gpio_port_decode.sv
module gpio_port_decode
  import gpio_port_pkg::*;
#(
  parameter int          ADDR_W    = 12,
  parameter logic [ADDR_W-1:0] ALIAS_OFS = 12'h080
) (
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  output logic [NUM_CTL-1:0] hit_full,
  output logic [NUM_CTL-1:0] hit_alias,
  output logic               hit_in,
  output logic [NUM_CTL-1:0] wr_full,
  output logic [NUM_CTL-1:0] wr_alias
);
  localparam logic [ADDR_W-1:0] IN_OFS = ADDR_W'(IN_INDEX * CTL_STRIDE);

  for (genvar i = 0; i < NUM_CTL; i++) begin : g_dec
    localparam logic [ADDR_W-1:0] FULL_OFS = ADDR_W'(i * CTL_STRIDE);
    assign hit_full[i]  = (bus_addr == FULL_OFS);
    assign hit_alias[i] = (bus_addr == (ALIAS_OFS + FULL_OFS));
  end

  assign hit_in   = (bus_addr == IN_OFS);
  assign wr_full  = hit_full  & {NUM_CTL{bus_sel & bus_wr}};
  assign wr_alias = hit_alias & {NUM_CTL{bus_sel & bus_wr}};
endmodule

// File: rtl/gpio_port_regs.sv
module gpio_port_regs
  import gpio_port_pkg::*;
#(
  parameter int          PIN_W     = 8,
  parameter int          DATA_W    = 32,
  parameter int          ADDR_W    = 12,
  parameter logic [ADDR_W-1:0] ALIAS_OFS = 12'h080
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic [PIN_W-1:0]  pad_in,
  output logic [PIN_W-1:0]  pad_out,
  output logic [PIN_W-1:0]  pad_oe
);
  localparam int PAD_HI = DATA_W - PIN_W;

  logic [NUM_CTL-1:0] hit_full;
  logic [NUM_CTL-1:0] hit_alias;
  logic               hit_in;
  logic [NUM_CTL-1:0] wr_full;
  logic [NUM_CTL-1:0] wr_alias;
  logic [PIN_W-1:0]   ctl_q [NUM_CTL];
  logic [PIN_W-1:0]   in_sync;
  logic [PIN_W-1:0]   in_view;
  logic [PIN_W-1:0]   rd_byte;

  gpio_port_decode #(
    .ADDR_W    (ADDR_W),
    .ALIAS_OFS (ALIAS_OFS)
  ) u_dec (
    .bus_sel   (bus_sel),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .hit_full  (hit_full),
    .hit_alias (hit_alias),
    .hit_in    (hit_in),
    .wr_full   (wr_full),
    .wr_alias  (wr_alias)
  );

  for (genvar i = 0; i < NUM_CTL; i++) begin : g_ctl
    gpio_port_ctlreg #(
      .PIN_W  (PIN_W),
      .DATA_W (DATA_W)
    ) u_reg (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_full   (wr_full[i]),
      .wr_masked (wr_alias[i]),
      .wdata     (bus_wdata),
      .q         (ctl_q[i])
    );
  end

  gpio_port_sync #(
    .PIN_W (PIN_W)
  ) u_sync (
    .clk      (clk),
    .rst_n    (rst_n),
    .async_in (pad_in),
    .sync_out (in_sync)
  );

  // driven pins report their drive level, others the synchronised pad
  assign in_view = (ctl_q[CTL_LEVEL] & ctl_q[CTL_DRVEN]) |
                   (in_sync & ~ctl_q[CTL_DRVEN]);

  always_comb begin
    rd_byte = '0;
    for (int i = 0; i < NUM_CTL; i++) begin
      if (hit_full[i] || hit_alias[i]) rd_byte = ctl_q[i];
    end
    if (hit_in) rd_byte = in_view;
  end

  assign bus_rdata = (bus_sel && !bus_wr) ? {{PAD_HI{1'b0}}, rd_byte} : '0;
  assign pad_out   = ctl_q[CTL_LEVEL];
  assign pad_oe    = ctl_q[CTL_OWN] & ctl_q[CTL_DRVEN];

  // R4
  alias_read_upper_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && !bus_wr && (hit_alias != '0)) |-> (bus_rdata[DATA_W-1:PIN_W] == '0));
  // R5
  release_ownership_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_full[CTL_OWN] && (bus_wdata[PIN_W-1:0] == '0)) |=> (pad_oe == '0));
  // R8
  input_write_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && bus_wr && hit_in) |=> ($stable(pad_oe) && $stable(pad_out)));
endmodule

// File: tb/tb_gpio_port_regs.sv
module tb_gpio_port_regs;
  localparam int CLK_PERIOD = 10;
  localparam int ALIAS      = 'h80;

  logic        clk;
  logic        rst_n;
  logic        bus_sel;
  logic        bus_wr;
  logic [11:0] bus_addr;
  logic [31:0] bus_wdata;
  logic [31:0] bus_rdata;
  logic [7:0]  pad_in;
  logic [7:0]  pad_out;
  logic [7:0]  pad_oe;

  int n_checks;
  int n_fail;
  bit finished;

  gpio_port_regs dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_sel   (bus_sel),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .pad_in    (pad_in),
    .pad_out   (pad_out),
    .pad_oe    (pad_oe)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    n_checks++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got 0x%08h expected 0x%08h", req, got, exp);
    end
  endtask

  task automatic bus_write(input logic [11:0] a, input logic [31:0] d, input logic sel = 1'b1);
    @(negedge clk);
    bus_sel = sel; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0; bus_wdata = '0;
  endtask

  task automatic bus_read(input logic [11:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
    #1 d = bus_rdata;
    bus_sel = 1'b0;
  endtask

  task automatic t_reset;
    logic [31:0] r;
    bus_read(12'h000, r); check("R1 own", r, 0);
    bus_read(12'h010, r); check("R1 drven", r, 0);
    bus_read(12'h020, r); check("R1 level", r, 0);
    check("R1 pad_out", {24'h0, pad_out}, 0);
    check("R1 pad_oe", {24'h0, pad_oe}, 0);
  endtask

  task automatic t_direct;
    logic [31:0] r;
    bus_write(12'h000, 32'hFFFF_FFA5);
    bus_read(12'h000, r); check("R2 R10 own", r, 32'h0000_00A5);
    bus_write(12'h010, 32'h1234_003C);
    bus_read(12'h010, r); check("R2 R10 drven", r, 32'h0000_003C);
    bus_write(12'h020, 32'h0000_FF0F);
    bus_read(12'h020, r); check("R2 level", r, 32'h0000_000F);
    check("R5 pad_out", {24'h0, pad_out}, 32'h0F);
    check("R5 pad_oe", {24'h0, pad_oe}, 32'h24);
  endtask

  task automatic t_masked;
    logic [31:0] r;
    bus_write(12'(ALIAS + 'h20), 32'h0000_0F05);
    bus_read(12'h020, r); check("R3 level low nibble", r, 32'h05);
    bus_write(12'(ALIAS + 'h20), 32'h0000_80FF);
    bus_read(12'h020, r); check("R3 level top bit", r, 32'h85);
    bus_write(12'(ALIAS + 'h20), 32'hFFFF_00FF);
    bus_read(12'(ALIAS + 'h20), r); check("R3 R4 empty mask alias read", r, 32'h85);
    bus_write(12'(ALIAS + 'h00), 32'h0000_8101);
    bus_read(12'h000, r); check("R3 own", r, 32'h25);
    check("R5 pad_oe after own", {24'h0, pad_oe}, 32'h24);
    bus_write(12'(ALIAS + 'h10), 32'h0000_FFC3);
    bus_read(12'(ALIAS + 'h10), r); check("R3 R4 drven", r, 32'hC3);
    check("R5 pad_oe after drven", {24'h0, pad_oe}, 32'h01);
    check("R5 pad_out", {24'h0, pad_out}, 32'h85);
  endtask

  task automatic t_sync;
    logic [31:0] r;
    bus_write(12'h010, 32'h0);
    @(negedge clk); pad_in = 8'h5A;
    bus_read(12'h030, r); check("R6 one edge", r, 32'h00);
    bus_read(12'h030, r); check("R6 two edges", r, 32'h5A);
  endtask

  task automatic t_view;
    logic [31:0] r;
    bus_write(12'h010, 32'hF0);
    bus_read(12'h030, r); check("R7 mixed view", r, 32'h8A);
  endtask

  task automatic t_ignored;
    logic [31:0] r;
    bus_write(12'h030, 32'hFFFF_FFFF);
    bus_write(12'(ALIAS + 'h30), 32'hFFFF_FFFF);
    bus_write(12'h044, 32'hFFFF_FFFF);
    bus_read(12'h000, r); check("R8 own kept", r, 32'h25);
    bus_read(12'h010, r); check("R8 drven kept", r, 32'hF0);
    bus_read(12'h020, r); check("R8 level kept", r, 32'h85);
    bus_read(12'h044, r); check("R8 unmapped read", r, 32'h0);
    bus_read(12'(ALIAS + 'h30), r); check("R8 input alias read", r, 32'h0);
  endtask

  task automatic t_nosel;
    logic [31:0] r;
    bus_write(12'h020, 32'h0000_0000, 1'b0);
    bus_write(12'h000, 32'h0000_00FF, 1'b0);
    check("R9 pad_out", {24'h0, pad_out}, 32'h85);
    bus_read(12'h000, r); check("R9 own", r, 32'h25);
  endtask

  initial begin
    finished = 1'b0;
    #(CLK_PERIOD * 100000);
    if (!finished) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog: got 0x%08h expected 0x%08h", 0, 1);
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    n_checks = 0; n_fail = 0;
    rst_n = 1'b0; bus_sel = 1'b0; bus_wr = 1'b0;
    bus_addr = '0; bus_wdata = '0; pad_in = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_direct();
    t_masked();
    t_sync();
    t_view();
    t_ignored();
    t_nosel();
    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule